// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside the instruction sequencer of a small processor core and decides which interrupt the core should take next. It merges eleven requestable sources into one vector. Four come from external active-low pins, one from a power-down pin and six from on-chip peripherals. The eleven sources share a fixed priority order with the reset slot, which holds vector 0x0000. Each request passes through a software mask, a global enable and a nesting filter. The highest-priority survivor is presented as `irq_valid` together with its vector address.

The sequencer answers with `ack` when it takes the interrupt and with `rti` when the handler returns. The controller keeps an in-service set and reports a push or pop event and the current nesting depth, so that the status stack outside the block can follow. Writes to the mask blank selection for one cycle but never hold off the peripheral request inputs. A control register chooses edge or level sensing for three of the pins and turns nesting on or off. A write-only force/clear port sets or drops pending latches.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Slot priority from highest to lowest is power-down (slot 0, vector 0x002C), selectable pin 2 (slot 1, 0x0004), level pin 1 (slot 2, 0x0008), level pin 0 (slot 3, 0x000C), serial 0 transmit (slot 4, 0x0010), serial 0 receive (slot 5, 0x0014), edge pin (slot 6, 0x0018), DMA done (slot 7, 0x001C), serial 1 transmit or selectable pin 1 (slot 8, 0x0020), serial 1 receive or selectable pin 0 (slot 9, 0x0024), timer (slot 10, 0x0028); among several pending unblocked slots the lowest slot number is presented.
- R2: A slot is eligible only if bit k of the mask register is 1. Bit 0 is ignored, so power-down cannot be masked.
- R3: After a mask write, `irq_valid` is low for exactly one output cycle and then recovers. Peripheral requests that arrive during that cycle are still captured.
- R4: The global enable is 1 after reset. While it is 0, no slot is presented, power-down included. Setting it again restores selection.
- R5: Control bit k (k = 0..2) set to 1 makes selectable pin k level-sensitive and set to 0 makes it edge-sensitive. Bit 3 set to 1 enables nesting. The register resets to 0.
- R6: An edge-sensitive pin raises a request on its falling edge after a two-flop synchronizer. Holding the pin low after the request is acknowledged does not raise a new one.
- R7: The two level pins are sampled directly and never latched. Their request follows the pin, and force or clear has no effect on them.
- R8: A force/clear write sets the pending latches named in `fc_set` and drops those named in `fc_clr`. Clear wins when both name the same slot.
- R9: An `ack` while `irq_valid` is high drops `irq_valid` on the next cycle, pulses `stk_push` for one cycle, raises `nest_depth` by one and drops the pending latch of that slot.
- R10: `rti` retires the highest-priority in-service slot, pulses `stk_pop` and lowers `nest_depth` by one. With depth 0 it is ignored.
- R11: With nesting on, only a slot of strictly higher priority than every in-service slot is presented. With nesting off, nothing is presented while depth is non-zero.
- R12: After reset `irq_valid` is 0, `irq_vector` is 0x0000, depth is 0 and no push or pop is reported. Depth never exceeds 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sel_n | input | 3 | Active-low pins with selectable edge/level sensing |
| ext_lvl_n | input | 2 | Active-low level-only pins |
| ext_edge_n | input | 1 | Active-low edge-only pin |
| pdown_n | input | 1 | Active-low power-down request pin (edge) |
| periph_req | input | 6 | Peripheral pulses: 0 ser0 tx, 1 ser0 rx, 2 DMA, 3 ser1 tx, 4 ser1 rx, 5 timer |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | Mask value, bit k enables slot k |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Sense selection [2:0], nesting enable [3] |
| fc_we | input | 1 | Force/clear write strobe |
| fc_set | input | 11 | Latches to force |
| fc_clr | input | 11 | Latches to clear |
| gie_set | input | 1 | Global enable on |
| gie_clr | input | 1 | Global enable off |
| ack | input | 1 | Sequencer takes presented interrupt |
| rti | input | 1 | Return from handler |
| irq_valid | output | 1 | A vector is presented |
| irq_vector | output | 14 | Vector address |
| stk_push | output | 1 | Status push event |
| stk_pop | output | 1 | Status pop event |
| nest_depth | output | 4 | Current nesting depth |

## Verification
Every pair of latchable slots is forced together. The presented vector must always belong to the lower slot number, which separates a correct priority encoder from one that is reversed or off by one. Mask sweeps with one enable bit at a time separate correct gating from ignored or shifted mask bits, and a zero mask with power-down forced shows that the unmaskable bypass works. Pin tests hold lines low across acknowledge and toggle the sense bits, which tells latched edge behaviour apart from direct level sampling. Nested acknowledge and return sequences with nesting on and off check the preemption rule and the depth count.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC = 11;
  localparam int ID_W = $clog2(NSRC);

  localparam int SL_PWR  = 0;
  localparam int SL_EXT2 = 1;
  localparam int SL_LVL1 = 2;
  localparam int SL_LVL0 = 3;
  localparam int SL_S0TX = 4;
  localparam int SL_S0RX = 5;
  localparam int SL_EXTE = 6;
  localparam int SL_DMA  = 7;
  localparam int SL_S1TX = 8;
  localparam int SL_S1RX = 9;
  localparam int SL_TMR  = 10;

  // slots whose request is sampled directly and never held in a latch
  localparam logic [NSRC-1:0] LEVEL_ONLY = NSRC'((1 << SL_LVL1) | (1 << SL_LVL0));
  // slots that bypass the mask register
  localparam logic [NSRC-1:0] NO_MASK    = NSRC'(1 << SL_PWR);
endpackage

// File: rtl/ivc_pin_sync.sv
module ivc_pin_sync #(
  parameter int N      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] act,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '1;
      else     sh_q <= {sh_q[STAGES-1:0], pin_n[g]};
    end
    assign act[g]  = ~sh_q[STAGES-1];
    assign fall[g] = sh_q[STAGES] & ~sh_q[STAGES-1];
  end
endmodule

// File: rtl/ivc_pend.sv
module ivc_pend
  import ivc_pkg::*;
#(
  parameter logic [NSRC-1:0] HOLD_MASK = ~LEVEL_ONLY
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_ev,
  input  logic [NSRC-1:0] lvl_act,
  input  logic [NSRC-1:0] ack_clr,
  input  logic            fc_we,
  input  logic [NSRC-1:0] fc_set,
  input  logic [NSRC-1:0] fc_clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] latch_q;
  logic [NSRC-1:0] frc_s, frc_c;

  assign frc_s = fc_we ? fc_set : '0;
  assign frc_c = fc_we ? fc_clr : '0;

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= ((latch_q & ~ack_clr) | set_ev | frc_s) & ~frc_c & HOLD_MASK;
  end

  assign pend = latch_q | lvl_act;

  AST_FC_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    fc_we |=> ((latch_q & $past(fc_clr)) == '0)); // R8
endmodule

// File: rtl/ivc_select.sv
module ivc_select
  import ivc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic            gate_open,
  input  logic            nest_en,
  input  logic [NSRC-1:0] isr,
  output logic            hit,
  output logic [ID_W-1:0] id
);
  logic [NSRC-1:0] elig;

  always_comb begin
    logic busy;
    logic allow;
    busy = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      busy    = busy | isr[i];
      allow   = nest_en ? ~busy : ~|isr;
      elig[i] = pend[i] & (mask[i] | NO_MASK[i]) & gate_open & allow;
    end
  end

  always_comb begin
    hit = 1'b0;
    id  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit = 1'b1;
        id  = ID_W'(i);
      end
    end
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pend[id] && (gate_open == 1'b1))); // R1
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int VEC_W       = 14,
  parameter int VEC_STEP    = 4,
  parameter int MAX_DEPTH   = 12,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH_W    = $clog2(MAX_DEPTH + 1),
  localparam int NPIN       = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         ext_sel_n,
  input  logic [1:0]         ext_lvl_n,
  input  logic               ext_edge_n,
  input  logic               pdown_n,
  input  logic [5:0]         periph_req,
  input  logic               mask_we,
  input  logic [NSRC-1:0]    mask_wdata,
  input  logic               ctrl_we,
  input  logic [3:0]         ctrl_wdata,
  input  logic               fc_we,
  input  logic [NSRC-1:0]    fc_set,
  input  logic [NSRC-1:0]    fc_clr,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               ack,
  input  logic               rti,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               stk_push,
  output logic               stk_pop,
  output logic [DEPTH_W-1:0] nest_depth
);
  logic [NPIN-1:0] pin_n_all, pin_act, pin_fall;
  logic [NSRC-1:0] mask_q, isr_q, isr_nx, set_ev, lvl_act, ack_clr, pop_bit, pend;
  logic [3:0]      ctrl_q;
  logic            gie_q, blank_q, valid_q, push_q, pop_q;
  logic [ID_W-1:0] id_q, sel_id;
  logic [VEC_W-1:0] vec_q, vec_nx;
  logic [DEPTH_W-1:0] depth_q;
  logic            hit, hit_ok, acc, do_pop, room;
  logic [2:0]      lvl_sel;

  assign pin_n_all = {pdown_n, ext_edge_n, ext_lvl_n, ext_sel_n};
  assign lvl_sel   = ctrl_q[2:0];

  ivc_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(pin_n_all), .act(pin_act), .fall(pin_fall)
  );

  // pin order: 0..2 selectable, 3..4 level-only, 5 edge-only, 6 power-down
  always_comb begin
    set_ev          = '0;
    lvl_act         = '0;
    set_ev[SL_PWR]  = pin_fall[6];
    set_ev[SL_EXT2] = pin_fall[2] & ~lvl_sel[2];
    set_ev[SL_S0TX] = periph_req[0];
    set_ev[SL_S0RX] = periph_req[1];
    set_ev[SL_EXTE] = pin_fall[5];
    set_ev[SL_DMA]  = periph_req[2];
    set_ev[SL_S1TX] = periph_req[3] | (pin_fall[1] & ~lvl_sel[1]);
    set_ev[SL_S1RX] = periph_req[4] | (pin_fall[0] & ~lvl_sel[0]);
    set_ev[SL_TMR]  = periph_req[5];
    lvl_act[SL_EXT2] = pin_act[2] & lvl_sel[2];
    lvl_act[SL_LVL1] = pin_act[4];
    lvl_act[SL_LVL0] = pin_act[3];
    lvl_act[SL_S1TX] = pin_act[1] & lvl_sel[1];
    lvl_act[SL_S1RX] = pin_act[0] & lvl_sel[0];
  end

  assign room   = depth_q < DEPTH_W'(MAX_DEPTH);
  assign acc    = ack & valid_q & room;
  assign do_pop = rti & (|isr_q);

  always_comb begin
    ack_clr = '0;
    if (acc) ack_clr[id_q] = 1'b1;
  end

  always_comb begin
    pop_bit = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (isr_q[i]) begin
        pop_bit    = '0;
        pop_bit[i] = 1'b1;
      end
    end
    if (!do_pop) pop_bit = '0;
  end

  assign isr_nx = (isr_q & ~pop_bit) | ack_clr;

  ivc_pend u_pend (
    .clk(clk), .rst(rst), .set_ev(set_ev), .lvl_act(lvl_act), .ack_clr(ack_clr),
    .fc_we(fc_we), .fc_set(fc_set), .fc_clr(fc_clr), .pend(pend)
  );

  ivc_select u_sel (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask_q), .gate_open(gie_q & ~blank_q),
    .nest_en(ctrl_q[3]), .isr(isr_q), .hit(hit), .id(sel_id)
  );

  assign hit_ok = hit & room;
  assign vec_nx = (sel_id == '0) ? VEC_W'(NSRC * VEC_STEP)
                                 : VEC_W'(int'(sel_id) * VEC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      ctrl_q  <= '0;
      gie_q   <= 1'b1;
      blank_q <= 1'b0;
      isr_q   <= '0;
      depth_q <= '0;
      valid_q <= 1'b0;
      id_q    <= '0;
      vec_q   <= '0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      blank_q <= mask_we;
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (gie_clr)      gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
      isr_q <= isr_nx;
      case ({acc, do_pop})
        2'b10:   depth_q <= depth_q + DEPTH_W'(1);
        2'b01:   depth_q <= depth_q - DEPTH_W'(1);
        default: depth_q <= depth_q;
      endcase
      push_q  <= acc;
      pop_q   <= do_pop;
      valid_q <= hit_ok & ~(ack & valid_q);
      if (hit_ok) begin
        id_q  <= sel_id;
        vec_q <= vec_nx;
      end
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
  assign stk_push   = push_q;
  assign stk_pop    = pop_q;
  assign nest_depth = depth_q;

  AST_BLANK_GAP: assert property (@(posedge clk) disable iff (rst)
    mask_we |-> ##2 !irq_valid); // R3
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid) |=> (!irq_valid && stk_push)); // R9
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    nest_depth <= DEPTH_W'(MAX_DEPTH)); // R12
  AST_DEPTH_TRACK: assert property (@(posedge clk) disable iff (rst)
    nest_depth == DEPTH_W'($countones(isr_q))); // R9
  AST_GIE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!gie_q && $past(!gie_q)) |-> !irq_valid); // R4
  AST_NEST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[3] && nest_depth != '0 && $past(!ctrl_q[3] && nest_depth != '0)) |-> !irq_valid); // R11
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    stk_pop |-> ($past(nest_depth) != '0)); // R10
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ext_sel_n = 3'b111;
  logic [1:0]  ext_lvl_n = 2'b11;
  logic        ext_edge_n = 1'b1;
  logic        pdown_n = 1'b1;
  logic [5:0]  periph_req = '0;
  logic        mask_we = 1'b0;
  logic [10:0] mask_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [3:0]  ctrl_wdata = '0;
  logic        fc_we = 1'b0;
  logic [10:0] fc_set = '0;
  logic [10:0] fc_clr = '0;
  logic        gie_set = 1'b0;
  logic        gie_clr = 1'b0;
  logic        ack = 1'b0;
  logic        rti = 1'b0;
  logic        irq_valid;
  logic [13:0] irq_vector;
  logic        stk_push, stk_pop;
  logic [3:0]  nest_depth;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_sel_n(ext_sel_n), .ext_lvl_n(ext_lvl_n),
    .ext_edge_n(ext_edge_n), .pdown_n(pdown_n), .periph_req(periph_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .fc_we(fc_we), .fc_set(fc_set), .fc_clr(fc_clr), .gie_set(gie_set), .gie_clr(gie_clr),
    .ack(ack), .rti(rti), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .stk_push(stk_push), .stk_pop(stk_pop), .nest_depth(nest_depth)
  );

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expv(input int slot);
    return ((slot == 0) ? 11 : slot) * 4;
  endfunction

  task automatic chk_vec(input string req, input int slot);
    chk(req, irq_valid, 1);
    chk(req, irq_vector, expv(slot));
  endtask

  task automatic wr_mask(input logic [10:0] v);
    mask_wdata = v; mask_we = 1'b1; tk(1); mask_we = 1'b0;
  endtask
  task automatic wr_ctrl(input logic [3:0] v);
    ctrl_wdata = v; ctrl_we = 1'b1; tk(1); ctrl_we = 1'b0;
  endtask
  task automatic wr_fc(input logic [10:0] s, input logic [10:0] c);
    fc_set = s; fc_clr = c; fc_we = 1'b1; tk(1); fc_we = 1'b0; fc_set = '0; fc_clr = '0;
  endtask
  task automatic do_ack;
    ack = 1'b1; tk(1); ack = 1'b0;
  endtask
  task automatic do_rti;
    rti = 1'b1; tk(1); rti = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tk(4);
    rst = 1'b0;
    tk(1);
    // R12 reset state
    chk("R12 valid", irq_valid, 0);
    chk("R12 vector", irq_vector, 0);
    chk("R12 depth", nest_depth, 0);
    chk("R12 push", stk_push, 0);
    chk("R12 pop", stk_pop, 0);

    // R1 pairwise priority sweep over latchable slots
    wr_mask(11'h7FF);
    tk(2);
    for (int i = 0; i < 11; i++) begin
      for (int j = i + 1; j < 11; j++) begin
        if (i != 2 && i != 3 && j != 2 && j != 3) begin
          wr_fc(11'(1 << i) | 11'(1 << j), '0);
          tk(3);
          chk_vec("R1 pair", i);
          wr_fc('0, 11'h7FF);
          tk(3);
          chk("R1 cleared", irq_valid, 0);
        end
      end
    end

    // R2 one-hot mask sweep, power-down excluded from force
    wr_fc(11'h7F2, '0);
    for (int k = 1; k < 11; k++) begin
      if (k != 2 && k != 3) begin
        wr_mask(11'(1 << k));
        tk(3);
        chk_vec("R2 mask onehot", k);
      end
    end
    wr_mask('0);
    tk(3);
    chk("R2 all masked", irq_valid, 0);
    wr_fc(11'h001, '0);
    tk(3);
    chk_vec("R2 power-down unmaskable", 0);
    wr_fc('0, 11'h7FF);

    // R3 blanking cycle with a DMA pulse inside it
    wr_mask(11'h7FF);
    wr_fc(11'(1 << 10), '0);
    tk(3);
    chk_vec("R3 before write", 10);
    mask_wdata = 11'h7FF; mask_we = 1'b1; periph_req[2] = 1'b1;
    tk(1);
    mask_we = 1'b0; periph_req = '0;
    chk("R3 same cycle", irq_valid, 1);
    tk(1);
    chk("R3 blank", irq_valid, 0);
    tk(1);
    chk_vec("R3 recovered with dma", 7);
    wr_fc('0, 11'h7FF);
    tk(3);

    // R4 global enable
    wr_fc(11'h001, '0);
    tk(3);
    chk_vec("R4 enabled after reset", 0);
    gie_clr = 1'b1; tk(1); gie_clr = 1'b0;
    tk(3);
    chk("R4 disabled blocks power-down", irq_valid, 0);
    gie_set = 1'b1; tk(1); gie_set = 1'b0;
    tk(3);
    chk_vec("R4 re-enabled", 0);
    wr_fc('0, 11'h7FF);
    tk(3);

    // R6 / R9 / R10 edge pin with acknowledge and return
    ext_edge_n = 1'b0;
    tk(6);
    chk_vec("R6 edge pin", 6);
    do_ack;
    chk("R9 valid drop", irq_valid, 0);
    chk("R9 push", stk_push, 1);
    chk("R9 depth", nest_depth, 1);
    tk(1);
    chk("R9 push one cycle", stk_push, 0);
    do_rti;
    chk("R10 pop", stk_pop, 1);
    chk("R10 depth", nest_depth, 0);
    tk(4);
    chk("R6 no retrigger held low", irq_valid, 0);
    ext_edge_n = 1'b1;
    tk(4);
    do_rti;
    chk("R10 ignored at depth 0", stk_pop, 0);
    chk("R10 depth stays 0", nest_depth, 0);

    // R5 selectable pin 2 in level then edge mode
    wr_ctrl(4'b0100);
    ext_sel_n[2] = 1'b0;
    tk(5);
    chk_vec("R5 level mode", 1);
    ext_sel_n[2] = 1'b1;
    tk(5);
    chk("R5 level released", irq_valid, 0);
    wr_ctrl(4'b0000);
    ext_sel_n[2] = 1'b0;
    tk(5);
    ext_sel_n[2] = 1'b1;
    tk(5);
    chk_vec("R5 edge mode holds", 1);
    wr_fc('0, 11'h002);
    tk(3);
    chk("R8 clear latch", irq_valid, 0);

    // R7 level-only pin
    ext_lvl_n[0] = 1'b0;
    tk(5);
    chk_vec("R7 level pin", 3);
    wr_fc('0, 11'h008);
    tk(3);
    chk_vec("R7 clear no effect", 3);
    ext_lvl_n[0] = 1'b1;
    tk(5);
    chk("R7 follows pin", irq_valid, 0);
    wr_fc(11'h008, '0);
    tk(3);
    chk("R7 force no effect", irq_valid, 0);

    // R8 clear wins
    wr_fc(11'h040, 11'h040);
    tk(3);
    chk("R8 clear wins", irq_valid, 0);

    // R11 nesting
    wr_ctrl(4'b1000);
    wr_fc(11'(1 << 10), '0);
    tk(3);
    do_ack;
    chk("R11 depth1", nest_depth, 1);
    wr_fc(11'(1 << 4), '0);
    tk(3);
    chk_vec("R11 higher preempts", 4);
    wr_fc(11'(1 << 7), '0);
    tk(3);
    chk_vec("R11 best still higher", 4);
    do_ack;
    chk("R11 depth2", nest_depth, 2);
    tk(3);
    chk("R11 lower blocked", irq_valid, 0);
    do_rti;
    chk("R11 pop depth1", nest_depth, 1);
    tk(3);
    chk_vec("R11 after return", 7);
    wr_ctrl(4'b0000);
    tk(3);
    chk("R11 nesting off blocks", irq_valid, 0);
    do_rti;
    tk(3);
    chk_vec("R11 served after full return", 7);
    wr_fc('0, 11'h7FF);
    tk(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule